// File: doc/BRIEF.md
# Lane Group Memory Request Coalescer

This unit sits between a set of parallel lanes and a single downstream memory request port. For each group it takes one byte address per lane, an activity mask and one access size for the whole group. It then decides whether the group can go out as one wide, aligned transaction. If it cannot, it splits the group into 128-byte segment requests. Each segment request carries a mask of the lanes it serves. The requests leave one at a time over a valid/ready handshake, and a one-cycle completion pulse closes the group.

A wide transaction is allowed only when three things hold. The access must be at least 4 bytes. The active lanes must form an ascending run in which lane i sits at base + i*size. The base must be aligned to sixteen times the access size. Every other group, including all 1- and 2-byte groups, takes the segmented path. The segments go out in ascending address order. Each lane address is expected to be naturally aligned to the access size, so no lane spans two segments.

Top module: `grp_coalescer`

## Requirements
- R1: After reset `grp_ready` is 1 and `req_valid` and `grp_done` are 0. A group is accepted on a clock edge where `grp_valid` and `grp_ready` are both high. `grp_ready` is high only while no group is in progress, and never together with `req_valid` or `grp_done`.
- R2: `size_code` values 0, 1, 2, 3 and 4 select 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 act as 16 bytes.
- R3: Let f be the lowest active lane, and let base = addr[f] - f*size. The group is combined into one request when all of these hold: size is at least 4, every active lane i has address base + i*size, and base is a multiple of 16*size (64, 128 or 256 bytes). That single request has `req_wide`=1, `req_addr`=base, `req_mask`=`lane_act` and `req_bytes`=16*size.
- R4: A group of 1-byte or 2-byte accesses is never combined, even when it is contiguous and aligned.
- R5: A group whose active lanes break the base + i*size pattern is not combined. An element stride of 3 (lanes at 0, 12, 24, 36... for 4-byte accesses) is one example.
- R6: A group that is not combined produces exactly one request for each distinct 128-byte segment touched by an active lane. Each such request has `req_wide`=0, `req_addr` equal to the segment start, `req_bytes`=128, and `req_mask` holding exactly the active lanes in that segment.
- R7: Segment requests of one group are issued in strictly ascending address order.
- R8: A pending request holds its address and mask until it is accepted. When `req_ready` stays high, one request is accepted in every cycle.
- R9: The address of an inactive lane has no effect on the requests that are produced.
- R10: A group with no active lanes produces no request. `grp_done` rises in the cycle after the group is accepted.
- R11: `grp_done` is a single-cycle pulse. It rises in the cycle after the edge that accepts the last request of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | 1 | A new lane group is presented |
| grp_ready | output | 1 | Unit is idle and will accept a group |
| lane_addr | input | LANES*AW | Byte address per lane, lane 0 in the low bits |
| lane_act | input | LANES | Lane activity mask |
| size_code | input | 3 | Access size code, size = 1 << min(code,4) |
| req_valid | output | 1 | Request to memory is pending |
| req_ready | input | 1 | Memory accepts the pending request |
| req_addr | output | AW | Start address of the request |
| req_bytes | output | BYTES_W | Request length in bytes |
| req_mask | output | LANES | Lanes served by the request |
| req_wide | output | 1 | Request is a combined wide transaction |
| grp_done | output | 1 | Group finished (one-cycle pulse) |

## Verification
The bench goes after groups that are contiguous but sit one size step off the required alignment. A design with the wrong alignment rule would combine them into a single request at a misaligned base. It also sends contiguous aligned 1- and 2-byte groups, which a design that ignores the size floor would merge. Groups with sparse activity masks and garbage addresses on the idle lanes expose any check that reads inactive lanes: such a design would drop to segments, or pick a wrong base. Stalls on the ready input, the empty group, and groups whose lanes fall into segments out of lane order check for repeated or reordered segments and for a completion pulse in the wrong cycle.

// File: rtl/gmc_pkg.sv
package gmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } gmc_state_e;

    localparam logic [2:0] MAX_SHIFT  = 3'd4;
    localparam logic [2:0] WIDE_SHIFT = 3'd2;
    localparam int         ALIGN_MULT = 16;

    function automatic logic [2:0] size_shift(input logic [2:0] code);
        return (code > MAX_SHIFT) ? MAX_SHIFT : code;
    endfunction

endpackage

// File: rtl/gmc_contig_check.sv
module gmc_contig_check #(
    parameter int LANES = 16,
    parameter int AW    = 32
) (
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES-1:0]    act,
    input  logic [2:0]          shift,
    output logic                wide_ok,
    output logic [AW-1:0]       base
);
    import gmc_pkg::*;

    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [AW-1:0]    lane [LANES];
    logic [LANES-1:0] lane_ok;
    logic [IDX_W-1:0] first;
    logic [AW-1:0]    align_mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g]    = addr_flat[g*AW +: AW];
        assign lane_ok[g] = !act[g] || (lane[g] == base + (AW'(g) << shift));
    end

    always_comb begin
        first = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (act[i]) first = IDX_W'(i);
        end
    end

    assign base       = lane[first] - (AW'(first) << shift);
    assign align_mask = (AW'(ALIGN_MULT) << shift) - AW'(1);
    assign wide_ok    = (|act) && (&lane_ok) && (shift >= WIDE_SHIFT)
                        && ((base & align_mask) == '0);

endmodule

// File: rtl/gmc_seg_pick.sv
module gmc_seg_pick #(
    parameter int LANES     = 16,
    parameter int AW        = 32,
    parameter int SEG_BYTES = 128
) (
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES-1:0]    rem,
    output logic [AW-1:0]       seg_addr,
    output logic [LANES-1:0]    seg_mask
);
    localparam logic [AW-1:0] SEG_CLR = ~AW'(SEG_BYTES - 1);

    logic [AW-1:0] key [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_key
        assign key[g]      = addr_flat[g*AW +: AW] & SEG_CLR;
        assign seg_mask[g] = rem[g] && (key[g] == seg_addr);
    end

    always_comb begin
        logic found;
        found    = 1'b0;
        seg_addr = '0;
        for (int i = 0; i < LANES; i++) begin
            if (rem[i] && (!found || key[i] < seg_addr)) begin
                seg_addr = key[i];
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/grp_coalescer.sv
module grp_coalescer #(
    parameter int LANES     = 16,
    parameter int AW        = 32,
    parameter int SEG_BYTES = 128,
    localparam int MAX_BYTES = (LANES * 16 > SEG_BYTES) ? LANES * 16 : SEG_BYTES,
    localparam int BYTES_W   = $clog2(MAX_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                grp_valid,
    output logic                grp_ready,
    input  logic [LANES*AW-1:0] lane_addr,
    input  logic [LANES-1:0]    lane_act,
    input  logic [2:0]          size_code,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [AW-1:0]       req_addr,
    output logic [BYTES_W-1:0]  req_bytes,
    output logic [LANES-1:0]    req_mask,
    output logic                req_wide,
    output logic                grp_done
);
    import gmc_pkg::*;

    gmc_state_e          st_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES-1:0]    act_q;
    logic [LANES-1:0]    rem_q;
    logic [2:0]          shift_q;

    logic                wide_ok;
    logic [AW-1:0]       wide_base;
    logic [AW-1:0]       seg_addr;
    logic [LANES-1:0]    seg_mask;
    logic                last_req;

    gmc_contig_check #(.LANES(LANES), .AW(AW)) u_contig (
        .addr_flat (addr_q),
        .act       (act_q),
        .shift     (shift_q),
        .wide_ok   (wide_ok),
        .base      (wide_base)
    );

    gmc_seg_pick #(.LANES(LANES), .AW(AW), .SEG_BYTES(SEG_BYTES)) u_seg (
        .addr_flat (addr_q),
        .rem       (rem_q),
        .seg_addr  (seg_addr),
        .seg_mask  (seg_mask)
    );

    assign grp_ready = (st_q == ST_IDLE);
    assign req_valid = (st_q == ST_ISSUE);
    assign grp_done  = (st_q == ST_DONE);
    assign req_wide  = wide_ok;
    assign req_addr  = wide_ok ? wide_base : seg_addr;
    assign req_mask  = wide_ok ? act_q : seg_mask;
    assign req_bytes = wide_ok ? (BYTES_W'(LANES) << shift_q) : BYTES_W'(SEG_BYTES);
    assign last_req  = wide_ok || ((rem_q & ~seg_mask) == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            act_q   <= '0;
            rem_q   <= '0;
            shift_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (grp_valid) begin
                        addr_q  <= lane_addr;
                        act_q   <= lane_act;
                        rem_q   <= lane_act;
                        shift_q <= size_shift(size_code);
                        st_q    <= (|lane_act) ? ST_ISSUE : ST_DONE;
                    end
                end
                ST_ISSUE: begin
                    if (req_ready) begin
                        rem_q <= rem_q & ~seg_mask;
                        if (last_req) st_q <= ST_DONE;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/gmc_checker.sv
module gmc_checker #(
    parameter int LANES   = 16,
    parameter int AW      = 32,
    parameter int BYTES_W = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               grp_valid,
    input logic               grp_ready,
    input logic               req_valid,
    input logic               req_ready,
    input logic [AW-1:0]      req_addr,
    input logic [BYTES_W-1:0] req_bytes,
    input logic [LANES-1:0]   req_mask,
    input logic               req_wide,
    input logic               grp_done
);

    p_idle_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        grp_ready |-> (!req_valid && !grp_done));

    p_wide_min_size_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_wide) |-> (req_bytes >= BYTES_W'(LANES * 4)));

    p_mask_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_mask != '0));

    p_ascending_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!req_valid || (req_addr > $past(req_addr))));

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_mask) && $stable(req_wide)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        grp_done |=> !grp_done);

    p_done_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(grp_done) |-> ($past(req_valid && req_ready) || $past(grp_valid && grp_ready)));

endmodule

bind grp_coalescer gmc_checker #(.LANES(LANES), .AW(AW), .BYTES_W(BYTES_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .grp_valid (grp_valid),
    .grp_ready (grp_ready),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_bytes (req_bytes),
    .req_mask  (req_mask),
    .req_wide  (req_wide),
    .grp_done  (grp_done)
);

// File: tb/tb_grp_coalescer.sv
module tb_grp_coalescer;
    localparam int LANES = 16;
    localparam int AW    = 32;
    localparam int BW    = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             grp_valid = 1'b0;
    logic             grp_ready;
    logic [LANES*AW-1:0] lane_addr = '0;
    logic [LANES-1:0] lane_act = '0;
    logic [2:0]       size_code = '0;
    logic             req_valid;
    logic             req_ready = 1'b0;
    logic [AW-1:0]    req_addr;
    logic [BW-1:0]    req_bytes;
    logic [LANES-1:0] req_mask;
    logic             req_wide;
    logic             grp_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    int seed_dummy;

    logic [AW-1:0]    ga [LANES];
    logic [AW-1:0]    e_addr [LANES];
    logic [LANES-1:0] e_mask [LANES];
    logic             e_wide;
    logic [BW-1:0]    e_bytes;
    int               e_n;

    always #5 clk = ~clk;

    grp_coalescer dut (
        .clk(clk), .rst(rst), .grp_valid(grp_valid), .grp_ready(grp_ready),
        .lane_addr(lane_addr), .lane_act(lane_act), .size_code(size_code),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_mask(req_mask), .req_wide(req_wide),
        .grp_done(grp_done)
    );

    task automatic check(input bit ok, input string req, input string msg,
                         input longint act_v, input longint exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, msg, act_v, exp_v);
        end
    endtask

    // Expected request list from the requirements (R2, R3, R4, R5, R6, R7, R9)
    task automatic build_expect(input logic [LANES-1:0] act, input logic [2:0] code);
        int s;
        int f;
        logic [AW-1:0] base;
        bit contig;
        logic [LANES-1:0] rem;
        s = (code > 3'd4) ? 4 : int'(code);
        f = -1;
        for (int i = LANES - 1; i >= 0; i--) if (act[i]) f = i;
        e_n = 0;
        e_wide = 1'b0;
        if (f < 0) return;
        base = ga[f] - AW'(f * (1 << s));
        contig = 1'b1;
        for (int i = 0; i < LANES; i++)
            if (act[i] && ga[i] != base + AW'(i * (1 << s))) contig = 1'b0;
        if (s >= 2 && contig && (base % AW'(16 * (1 << s))) == 0) begin
            e_wide = 1'b1;
            e_bytes = BW'(LANES * (1 << s));
            e_addr[0] = base;
            e_mask[0] = act;
            e_n = 1;
            return;
        end
        e_bytes = BW'(128);
        rem = act;
        while (rem != '0) begin
            logic [AW-1:0] mn;
            logic [LANES-1:0] m;
            mn = '1;
            for (int i = 0; i < LANES; i++)
                if (rem[i] && (ga[i] / 128) * 128 < mn) mn = (ga[i] / 128) * 128;
            m = '0;
            for (int i = 0; i < LANES; i++)
                if (rem[i] && (ga[i] / 128) * 128 == mn) m[i] = 1'b1;
            e_addr[e_n] = mn;
            e_mask[e_n] = m;
            e_n++;
            rem = rem & ~m;
        end
    endtask

    // ready_mode: 0 random, 1 always high
    task automatic run_group(input logic [LANES-1:0] act, input logic [2:0] code,
                             input int ready_mode, input string tag);
        int k;
        int cyc;
        bit last_acc;
        bit have_hold;
        bit done_seen;
        logic [AW-1:0] h_addr;
        logic [LANES-1:0] h_mask;
        build_expect(act, code);
        @(negedge clk);
        for (int i = 0; i < LANES; i++) lane_addr[i*AW +: AW] = ga[i];
        lane_act  = act;
        size_code = code;
        grp_valid = 1'b1;
        req_ready = 1'b0;
        #1;
        check(grp_ready == 1'b1, "R1", {tag, " idle ready"}, grp_ready, 1);
        @(negedge clk);
        grp_valid = 1'b0;
        k = 0; cyc = 0; last_acc = 0; have_hold = 0; done_seen = 0;
        while (!done_seen && cyc < 400) begin
            req_ready = (ready_mode == 1) ? 1'b1 : (($urandom % 10) < 6);
            #1;
            if (grp_done) begin
                check(k == e_n, "R6", {tag, " request count"}, k, e_n);
                if (e_n == 0)
                    check(cyc == 0, "R10", {tag, " empty done timing"}, cyc, 0);
                else
                    check(last_acc, "R11", {tag, " done after last accept"}, last_acc, 1);
                if (ready_mode == 1)
                    check(cyc == e_n, "R8", {tag, " back-to-back issue"}, cyc, e_n);
                done_seen = 1;
            end else begin
                if (req_valid)
                    check(!grp_ready, "R1", {tag, " ready while busy"}, grp_ready, 0);
                if (have_hold)
                    check(req_valid && req_addr == h_addr && req_mask == h_mask,
                          "R8", {tag, " hold while stalled"}, req_addr, h_addr);
                last_acc = 0;
                if (req_valid) begin
                    if (k >= e_n) begin
                        check(0, "R6", {tag, " extra request"}, req_addr, 0);
                    end else if (req_ready) begin
                        check(req_addr == e_addr[k] && req_mask == e_mask[k] &&
                              req_wide == e_wide && req_bytes == e_bytes,
                              e_wide ? "R3" : "R6", {tag, " request addr/mask"},
                              {req_addr, req_mask}, {e_addr[k], e_mask[k]});
                        if (!e_wide && k > 0)
                            check(req_addr > e_addr[k-1], "R7", {tag, " ascending"},
                                  req_addr, e_addr[k-1]);
                        k++;
                        last_acc = (k == e_n);
                        have_hold = 0;
                    end else begin
                        have_hold = 1;
                        h_addr = req_addr;
                        h_mask = req_mask;
                    end
                end
            end
            @(negedge clk);
            cyc++;
        end
        if (!done_seen) check(0, "R11", {tag, " no done"}, 0, 1);
        req_ready = 1'b0;
    endtask

    task automatic set_contig(input logic [AW-1:0] base, input int s, input int stride);
        for (int i = 0; i < LANES; i++) ga[i] = base + AW'(i * stride * (1 << s));
    endtask

    task automatic set_random(input int s);
        logic [AW-1:0] win;
        win = AW'(($urandom % 256) * 256);
        for (int i = 0; i < LANES; i++)
            ga[i] = win + AW'(($urandom % (1024 >> s)) << s);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        seed_dummy = $urandom(32'h5eed_c0a1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(grp_ready && !req_valid && !grp_done, "R1", "reset state",
              {grp_ready, req_valid, grp_done}, 3'b100);

        // R3: aligned contiguous 4/8/16-byte groups combine
        set_contig(32'h0000_1000, 2, 1); run_group('1, 3'd2, 1, "R3 w4");
        set_contig(32'h0000_2080, 3, 1); run_group('1, 3'd3, 0, "R3 w8");
        set_contig(32'h0000_3100, 4, 1); run_group('1, 3'd4, 0, "R3 w16");
        // R2: codes above 4 act as 16 bytes
        set_contig(32'h0000_3100, 4, 1); run_group('1, 3'd7, 0, "R2 code7");
        // R3: base one size step off alignment splits
        set_contig(32'h0000_1020, 2, 1); run_group('1, 3'd2, 0, "R3 mis64");
        set_contig(32'h0000_2040, 3, 1); run_group('1, 3'd3, 0, "R3 mis128");
        set_contig(32'h0000_3080, 4, 1); run_group('1, 3'd4, 1, "R3 mis256");
        // R4: narrow contiguous aligned never combine
        set_contig(32'h0000_4000, 0, 1); run_group('1, 3'd0, 1, "R4 b1");
        set_contig(32'h0000_4000, 1, 1); run_group('1, 3'd1, 0, "R4 b2");
        // R5: stride of three elements
        set_contig(32'h0000_5000, 2, 3); run_group('1, 3'd2, 0, "R5 stride3");
        // R9: inactive lanes carry garbage, partial mask still combines
        set_contig(32'h0000_6000, 2, 1);
        ga[0] = 32'hdead_beef; ga[7] = 32'h0000_0013; ga[15] = 32'h1234_5678;
        run_group(16'b0111_1111_0111_1110, 3'd2, 0, "R9 garbage");
        // R10: empty group
        set_random(2); run_group('0, 3'd2, 0, "R10 empty");
        // R7: lanes in reverse segment order
        for (int i = 0; i < LANES; i++) ga[i] = 32'h0000_8000 + AW'((LANES - 1 - i) * 128);
        run_group('1, 3'd2, 0, "R7 reverse");

        // Mixed random groups
        for (int n = 0; n < 300; n++) begin
            int s;
            int kind;
            logic [LANES-1:0] act;
            s = $urandom % 5;
            kind = $urandom % 4;
            act = (($urandom % 4) == 0) ? LANES'($urandom) : '1;
            if (kind == 0)
                set_contig(AW'(($urandom % 64) * (16 << s)), s, 1);
            else if (kind == 1)
                set_contig(AW'(($urandom % 512) << s), s, 1);
            else if (kind == 2)
                set_contig(AW'(($urandom % 64) * 256), s, 1 + ($urandom % 5));
            else
                set_random(s);
            run_group(act, 3'(s), ($urandom % 3 == 0) ? 1 : 0, "R6 random");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule